// File: doc/BRIEF.md
# Parallel Port Pair with Input Latching and Handshake Lines

This block holds the two data ports of a parallel interface adapter: port A and port B. Each port has an output register, a direction register, and an optional capture latch that is loaded on an active edge of the port's first control line. Each port also has a second control line. That line works either as an interrupt input or as an output, and as an output it can be a handshake strobe, a one-cycle pulse, or a fixed level. A register-select bus with read and write strobes reaches the port, direction and configuration registers. Reads come back combinationally on `rd_data_o` in the strobe cycle.

The block keeps no interrupt flags. In each cycle it sends one-cycle set requests and clear requests to a separate interrupt controller, using the flag bit positions given below. A port access clears the flags of that port's control lines. The exception is when the second line of that port is an independent interrupt input: then the flags are left alone. A quiet alias of port A lets software sample the port without disturbing the flags or the handshake.

Register map: 0 is port B, 1 is port A with side effects, 2 is direction B, 3 is direction A, 11 is latch control, 12 is line control, and 15 is port A quiet. All other addresses read 0. Latch control uses bit 0 to enable the A latch and bit 1 to enable the B latch. Line control is laid out as follows:
- Bit 0 selects the A first-line edge (1 means rising).
- Bits 3:1 hold the A second-line mode.
- Bit 4 selects the B first-line edge.
- Bits 7:5 hold the B second-line mode.

The second-line mode codes are:
- 0: input, falling edge.
- 1: independent input, falling edge.
- 2: input, rising edge.
- 3: independent input, rising edge.
- 4: handshake output.
- 5: pulse output.
- 6: drive low.
- 7: drive high.

Top module: `pport_pair`

## Requirements
- R1: With the latch disabled, reading port A (address 1) or port B (address 0) returns (output_register OR NOT direction_register) AND pins. A direction bit of 1 means output.
- R2: When a port's latch is enabled, reading that port returns the value captured at the last active edge of its first control line. Port A captures the raw pins. Port B captures its R1 value.
- R3: A first control line requests a flag set in the cycle in which it differs from its previous-cycle value in the selected direction. CA1 uses flag bit 1 and CB1 uses flag bit 4.
- R4: In modes 0 to 3, a second control line edge of the polarity given by mode bit 1 requests a flag set. CA2 uses flag bit 0 and CB2 uses flag bit 3.
- R5: A read or write of address 1 requests clearing of flag bits 0 and 1. A read or write of address 0 requests clearing of flag bits 3 and 4. No clear is requested when that port's second line is in mode 1 or 3.
- R6: A read of address 15 returns the same value as address 1. It requests no clear and does not start a handshake.
- R7: In mode 5, a write to the port drives the second line low for exactly one cycle, starting at the next clock edge.
- R8: In mode 4, a read or write of port A drives CA2 low from the next edge until an active CA1 edge. A write to port B does the same for CB2 until an active CB1 edge.
- R9: Modes 6 and 7 drive the second line low and high. The output enable is high exactly in modes 4 to 7, and an undriven line outputs high.
- R10: After reset, the following hold:
  - Output, direction, control and latch registers are all 0.
  - Both second lines are undriven and high.
  - No set or clear requests are made.
- R11: The direction registers, latch control (2 bits) and line control (8 bits) read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sel_i | input | ADDR_W | Register select |
| rd_stb_i | input | 1 | Read strobe, one cycle per access |
| wr_stb_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | PORT_W | Write data |
| rd_data_o | output | PORT_W | Read data for the selected register |
| pa_pins_i | input | PORT_W | Port A pin levels |
| pb_pins_i | input | PORT_W | Port B pin levels |
| pa_out_o | output | PORT_W | Port A output register |
| pa_dir_o | output | PORT_W | Port A direction register |
| pb_out_o | output | PORT_W | Port B output register |
| pb_dir_o | output | PORT_W | Port B direction register |
| ca1_i | input | 1 | Port A first control line |
| ca2_i | input | 1 | Port A second control line, input level |
| cb1_i | input | 1 | Port B first control line |
| cb2_i | input | 1 | Port B second control line, input level |
| ca2_o | output | 1 | Port A second control line, output level |
| ca2_oe_o | output | 1 | Port A second control line, output enable |
| cb2_o | output | 1 | Port B second control line, output level |
| cb2_oe_o | output | 1 | Port B second control line, output enable |
| flag_set_o | output | 8 | Flag set requests |
| flag_clr_o | output | 8 | Flag clear requests |

## Verification
A latched port A read and an active CA1 edge can fall in the same cycle. In that cycle the block must raise both the clear request and the set request for flag bit 1. The read must return the old latch contents, and the new capture must only show on the following read. The bench provokes this by moving CA1 and the pins on the very cycle its read strobe is high. It then judges the read data, both request vectors, and the data of a second read.

// File: rtl/pport_pkg.sv
package pport_pkg;

   typedef enum logic [2:0] {
      L2_IN_FALL   = 3'd0,
      L2_IND_FALL  = 3'd1,
      L2_IN_RISE   = 3'd2,
      L2_IND_RISE  = 3'd3,
      L2_HANDSHAKE = 3'd4,
      L2_PULSE     = 3'd5,
      L2_FORCE_LO  = 3'd6,
      L2_FORCE_HI  = 3'd7
   } line2_mode_e;

   localparam int unsigned ADR_PORT_B  = 0;
   localparam int unsigned ADR_PORT_A  = 1;
   localparam int unsigned ADR_DIR_B   = 2;
   localparam int unsigned ADR_DIR_A   = 3;
   localparam int unsigned ADR_LATCTL  = 11;
   localparam int unsigned ADR_LINECTL = 12;
   localparam int unsigned ADR_QUIET_A = 15;

   localparam int unsigned FLAG_W  = 8;
   localparam int unsigned FLG_A2  = 0;
   localparam int unsigned FLG_A1  = 1;
   localparam int unsigned FLG_B2  = 3;
   localparam int unsigned FLG_B1  = 4;

   function automatic logic mode_is_input(input line2_mode_e m);
      return ~m[2];
   endfunction

   function automatic logic mode_is_indep(input line2_mode_e m);
      return (m == L2_IND_FALL) || (m == L2_IND_RISE);
   endfunction

   function automatic logic mode_rising(input line2_mode_e m);
      return m[1];
   endfunction

endpackage

// File: rtl/pport_edge.sv
module pport_edge #(
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   input  logic rising_i,
   output logic active_o
);
   logic prev_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) prev_q <= IDLE_LEVEL;
      else         prev_q <= line_i;
   end

   always_comb begin
      if (rising_i) active_o = line_i & ~prev_q;
      else          active_o = ~line_i & prev_q;
   end
endmodule

// File: rtl/pport_side.sv
module pport_side
   import pport_pkg::*;
#(
   parameter int unsigned PORT_W      = 8,
   parameter bit          HAS_LATCH   = 1'b1,
   parameter bit          IS_PORT_A   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [PORT_W-1:0] pins_i,
   input  logic [PORT_W-1:0] wdata_i,
   input  logic              out_we_i,
   input  logic              dir_we_i,
   input  logic              access_i,
   input  logic              write_i,
   input  logic              lat_en_i,
   input  logic              line1_rise_i,
   input  line2_mode_e       mode2_i,
   input  logic              line1_i,
   input  logic              line2_i,
   output logic [PORT_W-1:0] out_q_o,
   output logic [PORT_W-1:0] dir_q_o,
   output logic [PORT_W-1:0] rd_val_o,
   output logic              line2_o,
   output logic              line2_oe_o,
   output logic              set1_o,
   output logic              set2_o,
   output logic              clr_o
);
   logic [PORT_W-1:0] out_q, dir_q, live_val, cap_val;
   logic              edge1, edge2;
   logic              hs_q, pulse_q, hs_trigger;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         out_q <= '0;
         dir_q <= '0;
      end else begin
         if (out_we_i) out_q <= wdata_i;
         if (dir_we_i) dir_q <= wdata_i;
      end
   end

   assign live_val = (out_q | ~dir_q) & pins_i;
   assign out_q_o  = out_q;
   assign dir_q_o  = dir_q;

   pport_edge #(.IDLE_LEVEL(1'b1)) u_edge1 (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .line_i   (line1_i),
      .rising_i (line1_rise_i),
      .active_o (edge1)
   );

   pport_edge #(.IDLE_LEVEL(1'b1)) u_edge2 (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .line_i   (line2_i),
      .rising_i (mode_rising(mode2_i)),
      .active_o (edge2)
   );

   assign set1_o = edge1;
   assign set2_o = edge2 & mode_is_input(mode2_i);
   assign clr_o  = access_i & ~mode_is_indep(mode2_i);

   generate
      if (IS_PORT_A) begin : g_cap_raw
         assign cap_val    = pins_i;
         assign hs_trigger = access_i;
      end else begin : g_cap_eff
         assign cap_val    = live_val;
         assign hs_trigger = write_i;
      end
   endgenerate

   generate
      if (HAS_LATCH) begin : g_latch
         logic [PORT_W-1:0] latch_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)    latch_q <= '0;
            else if (edge1) latch_q <= cap_val;
         end
         assign rd_val_o = lat_en_i ? latch_q : live_val;

         p_latch_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !edge1 |=> $stable(latch_q));
      end else begin : g_no_latch
         logic unused_lat;
         assign unused_lat = lat_en_i ^ (|cap_val);
         assign rd_val_o   = live_val;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hs_q    <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= (mode2_i == L2_PULSE) && write_i;
         if (mode2_i != L2_HANDSHAKE) hs_q <= 1'b0;
         else if (hs_trigger)         hs_q <= 1'b1;
         else if (edge1)              hs_q <= 1'b0;
      end
   end

   always_comb begin
      case (mode2_i)
         L2_HANDSHAKE: line2_o = ~hs_q;
         L2_PULSE:     line2_o = ~pulse_q;
         L2_FORCE_LO:  line2_o = 1'b0;
         default:      line2_o = 1'b1;
      endcase
   end
   assign line2_oe_o = ~mode_is_input(mode2_i);

   p_pulse_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode2_i == L2_PULSE && !line2_o && !write_i) |=> (line2_o || mode2_i != L2_PULSE));

   p_hs_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hs_q && edge1 && !hs_trigger) |=> !hs_q);

   p_idle_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !line2_oe_o |-> line2_o);

endmodule

// File: rtl/pport_pair.sv
module pport_pair
   import pport_pkg::*;
#(
   parameter int unsigned PORT_W    = 8,
   parameter int unsigned ADDR_W    = 4,
   parameter bit          HAS_LATCH = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] sel_i,
   input  logic              rd_stb_i,
   input  logic              wr_stb_i,
   input  logic [PORT_W-1:0] wdata_i,
   output logic [PORT_W-1:0] rd_data_o,
   input  logic [PORT_W-1:0] pa_pins_i,
   input  logic [PORT_W-1:0] pb_pins_i,
   output logic [PORT_W-1:0] pa_out_o,
   output logic [PORT_W-1:0] pa_dir_o,
   output logic [PORT_W-1:0] pb_out_o,
   output logic [PORT_W-1:0] pb_dir_o,
   input  logic              ca1_i,
   input  logic              ca2_i,
   input  logic              cb1_i,
   input  logic              cb2_i,
   output logic              ca2_o,
   output logic              ca2_oe_o,
   output logic              cb2_o,
   output logic              cb2_oe_o,
   output logic [7:0]        flag_set_o,
   output logic [7:0]        flag_clr_o
);
   localparam int unsigned CTL_W = 8;
   localparam int unsigned LAT_W = 2;

   initial begin
      if (PORT_W < CTL_W) $fatal(1, "PORT_W must be at least %0d", CTL_W);
      if (ADDR_W < 4)     $fatal(1, "ADDR_W must be at least 4");
   end

   logic [LAT_W-1:0] latctl_q;
   logic [CTL_W-1:0] linectl_q;
   line2_mode_e      mode_a2, mode_b2;
   logic             hit_pa, hit_pb, hit_da, hit_db, hit_lat, hit_line, hit_qa;
   logic [PORT_W-1:0] rd_a, rd_b;
   logic             set_a1, set_a2, set_b1, set_b2, clr_a, clr_b;

   assign hit_pa   = sel_i == ADDR_W'(ADR_PORT_A);
   assign hit_pb   = sel_i == ADDR_W'(ADR_PORT_B);
   assign hit_da   = sel_i == ADDR_W'(ADR_DIR_A);
   assign hit_db   = sel_i == ADDR_W'(ADR_DIR_B);
   assign hit_lat  = sel_i == ADDR_W'(ADR_LATCTL);
   assign hit_line = sel_i == ADDR_W'(ADR_LINECTL);
   assign hit_qa   = sel_i == ADDR_W'(ADR_QUIET_A);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         latctl_q  <= '0;
         linectl_q <= '0;
      end else if (wr_stb_i) begin
         if (hit_lat)  latctl_q  <= wdata_i[LAT_W-1:0];
         if (hit_line) linectl_q <= wdata_i[CTL_W-1:0];
      end
   end

   assign mode_a2 = line2_mode_e'(linectl_q[3:1]);
   assign mode_b2 = line2_mode_e'(linectl_q[7:5]);

   pport_side #(.PORT_W(PORT_W), .HAS_LATCH(HAS_LATCH), .IS_PORT_A(1'b1)) u_side_a (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pins_i       (pa_pins_i),
      .wdata_i      (wdata_i),
      .out_we_i     (wr_stb_i & hit_pa),
      .dir_we_i     (wr_stb_i & hit_da),
      .access_i     ((rd_stb_i | wr_stb_i) & hit_pa),
      .write_i      (wr_stb_i & hit_pa),
      .lat_en_i     (latctl_q[0]),
      .line1_rise_i (linectl_q[0]),
      .mode2_i      (mode_a2),
      .line1_i      (ca1_i),
      .line2_i      (ca2_i),
      .out_q_o      (pa_out_o),
      .dir_q_o      (pa_dir_o),
      .rd_val_o     (rd_a),
      .line2_o      (ca2_o),
      .line2_oe_o   (ca2_oe_o),
      .set1_o       (set_a1),
      .set2_o       (set_a2),
      .clr_o        (clr_a)
   );

   pport_side #(.PORT_W(PORT_W), .HAS_LATCH(HAS_LATCH), .IS_PORT_A(1'b0)) u_side_b (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pins_i       (pb_pins_i),
      .wdata_i      (wdata_i),
      .out_we_i     (wr_stb_i & hit_pb),
      .dir_we_i     (wr_stb_i & hit_db),
      .access_i     ((rd_stb_i | wr_stb_i) & hit_pb),
      .write_i      (wr_stb_i & hit_pb),
      .lat_en_i     (latctl_q[1]),
      .line1_rise_i (linectl_q[4]),
      .mode2_i      (mode_b2),
      .line1_i      (cb1_i),
      .line2_i      (cb2_i),
      .out_q_o      (pb_out_o),
      .dir_q_o      (pb_dir_o),
      .rd_val_o     (rd_b),
      .line2_o      (cb2_o),
      .line2_oe_o   (cb2_oe_o),
      .set1_o       (set_b1),
      .set2_o       (set_b2),
      .clr_o        (clr_b)
   );

   always_comb begin
      flag_set_o         = '0;
      flag_set_o[FLG_A1] = set_a1;
      flag_set_o[FLG_A2] = set_a2;
      flag_set_o[FLG_B1] = set_b1;
      flag_set_o[FLG_B2] = set_b2;
      flag_clr_o         = '0;
      flag_clr_o[FLG_A1] = clr_a;
      flag_clr_o[FLG_A2] = clr_a;
      flag_clr_o[FLG_B1] = clr_b;
      flag_clr_o[FLG_B2] = clr_b;
   end

   always_comb begin
      rd_data_o = '0;
      if (hit_pa || hit_qa) rd_data_o = rd_a;
      else if (hit_pb)      rd_data_o = rd_b;
      else if (hit_da)      rd_data_o = pa_dir_o;
      else if (hit_db)      rd_data_o = pb_dir_o;
      else if (hit_lat)     rd_data_o = PORT_W'(latctl_q);
      else if (hit_line)    rd_data_o = PORT_W'(linectl_q);
   end

   p_quiet_no_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_stb_i && !wr_stb_i && hit_qa) |-> (flag_clr_o == '0));

   p_indep_keeps_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_is_indep(mode_a2) |-> !flag_clr_o[FLG_A1]);

   p_indep_keeps_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_is_indep(mode_b2) |-> !flag_clr_o[FLG_B1]);

   p_set_bits_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_set_o & 8'hE4) == 8'h00);

   p_out_mode_set_none_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ca2_oe_o |-> !flag_set_o[FLG_A2]);

endmodule

// File: tb/test_pport_pair.sv
module test_pport_pair;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] sel = '0;
   logic       rd_stb = 1'b0, wr_stb = 1'b0;
   logic [7:0] wdata = '0, rd_data;
   logic [7:0] pa_pins = '0, pb_pins = '0;
   logic [7:0] pa_out, pa_dir, pb_out, pb_dir;
   logic       ca1 = 1'b1, ca2 = 1'b1, cb1 = 1'b1, cb2 = 1'b1;
   logic       ca2_o, ca2_oe, cb2_o, cb2_oe;
   logic [7:0] fset, fclr;
   int         total = 0, bad = 0;
   logic [7:0] d, c, s;

   always #10 clk = ~clk;

   pport_pair i_pport_pair (
      .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rd_stb_i(rd_stb), .wr_stb_i(wr_stb),
      .wdata_i(wdata), .rd_data_o(rd_data), .pa_pins_i(pa_pins), .pb_pins_i(pb_pins),
      .pa_out_o(pa_out), .pa_dir_o(pa_dir), .pb_out_o(pb_out), .pb_dir_o(pb_dir),
      .ca1_i(ca1), .ca2_i(ca2), .cb1_i(cb1), .cb2_i(cb2),
      .ca2_o(ca2_o), .ca2_oe_o(ca2_oe), .cb2_o(cb2_o), .cb2_oe_o(cb2_oe),
      .flag_set_o(fset), .flag_clr_o(fclr)
   );

   task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] v, output logic [7:0] clr);
      @(negedge clk); sel = a; wdata = v; wr_stb = 1'b1;
      #2 clr = fclr;
      @(negedge clk); wr_stb = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v, output logic [7:0] clr, output logic [7:0] st);
      @(negedge clk); sel = a; rd_stb = 1'b1;
      #2 v = rd_data; clr = fclr; st = fset;
      @(negedge clk); rd_stb = 1'b0;
   endtask

   task automatic t_reset;
      #2;
      chk("R10", "ca2 level", {7'd0, ca2_o}, 8'h01);
      chk("R10", "ca2 enable", {7'd0, ca2_oe}, 8'h00);
      chk("R10", "cb2 level", {7'd0, cb2_o}, 8'h01);
      chk("R10", "set idle", fset, 8'h00);
      chk("R10", "clr idle", fclr, 8'h00);
      rd(4'd3, d, c, s); chk("R10", "dir A", d, 8'h00);
      rd(4'd12, d, c, s); chk("R10", "line ctl", d, 8'h00);
      wr(4'd11, 8'h03, c);
      rd(4'd1, d, c, s); chk("R10", "latch A zero", d, 8'h00);
      rd(4'd0, d, c, s); chk("R10", "latch B zero", d, 8'h00);
      wr(4'd11, 8'h00, c);
   endtask

   task automatic t_readback;
      wr(4'd2, 8'h3C, c); rd(4'd2, d, c, s); chk("R11", "dir B", d, 8'h3C);
      wr(4'd11, 8'hFF, c); rd(4'd11, d, c, s); chk("R11", "latch ctl", d, 8'h03);
      wr(4'd12, 8'h5A, c); rd(4'd12, d, c, s); chk("R11", "line ctl", d, 8'h5A);
      wr(4'd12, 8'h00, c); wr(4'd11, 8'h00, c);
   endtask

   task automatic t_merge;
      wr(4'd3, 8'hF0, c); wr(4'd1, 8'hA5, c);
      pa_pins = 8'h3C;
      rd(4'd1, d, c, s); chk("R1", "port A merge", d, 8'h2C);
      wr(4'd2, 8'hFF, c); wr(4'd0, 8'h5A, c);
      pb_pins = 8'hF0;
      rd(4'd0, d, c, s); chk("R1", "port B all out", d, 8'h50);
      wr(4'd2, 8'h00, c); pb_pins = 8'h81;
      rd(4'd0, d, c, s); chk("R1", "port B all in", d, 8'h81);
   endtask

   task automatic t_edge;
      wr(4'd12, 8'h01, c);
      @(negedge clk); ca1 = 1'b0; #2 chk("R3", "fall ignored in rise mode", fset, 8'h00);
      @(negedge clk); ca1 = 1'b1; #2 chk("R3", "rise sets bit1", fset, 8'h02);
      wr(4'd12, 8'h00, c);
      @(negedge clk); ca1 = 1'b0; #2 chk("R3", "fall sets bit1", fset, 8'h02);
      @(negedge clk); ca1 = 1'b1; #2 chk("R3", "rise ignored in fall mode", fset, 8'h00);
      @(negedge clk); cb1 = 1'b0; #2 chk("R3", "cb1 fall sets bit4", fset, 8'h10);
      @(negedge clk); cb1 = 1'b1;
   endtask

   task automatic t_latch;
      wr(4'd11, 8'h01, c);
      wr(4'd3, 8'hFF, c); wr(4'd1, 8'h00, c);
      @(negedge clk); pa_pins = 8'h77; ca1 = 1'b0;
      @(negedge clk); pa_pins = 8'h11; ca1 = 1'b1;
      rd(4'd1, d, c, s); chk("R2", "A latched raw pins", d, 8'h77);
      wr(4'd11, 8'h00, c);
      rd(4'd1, d, c, s); chk("R2", "A live when disabled", d, 8'h00);
      wr(4'd11, 8'h02, c);
      wr(4'd2, 8'h0F, c); wr(4'd0, 8'h03, c);
      @(negedge clk); pb_pins = 8'hF5; cb1 = 1'b0;
      @(negedge clk); pb_pins = 8'h00; cb1 = 1'b1;
      rd(4'd0, d, c, s); chk("R2", "B latched effective", d, 8'hF1);
      wr(4'd11, 8'h00, c);
   endtask

   task automatic t_line2_in;
      wr(4'd12, 8'h04, c);
      @(negedge clk); ca2 = 1'b0; #2 chk("R4", "ca2 fall ignored", fset, 8'h00);
      @(negedge clk); ca2 = 1'b1; #2 chk("R4", "ca2 rise sets bit0", fset, 8'h01);
      wr(4'd12, 8'h00, c);
      @(negedge clk); ca2 = 1'b0; #2 chk("R4", "ca2 fall sets bit0", fset, 8'h01);
      @(negedge clk); ca2 = 1'b1;
      wr(4'd12, 8'h40, c);
      @(negedge clk); cb2 = 1'b0;
      @(negedge clk); cb2 = 1'b1; #2 chk("R4", "cb2 rise sets bit3", fset, 8'h08);
      wr(4'd12, 8'h0C, c);
      @(negedge clk); ca2 = 1'b0; #2 chk("R4", "ca2 output mode no set", fset, 8'h00);
      @(negedge clk); ca2 = 1'b1;
      wr(4'd12, 8'h00, c);
   endtask

   task automatic t_clear;
      rd(4'd1, d, c, s); chk("R5", "A read clears", c, 8'h03);
      wr(4'd12, 8'h02, c);
      rd(4'd1, d, c, s); chk("R5", "A indep keeps", c, 8'h00);
      wr(4'd12, 8'h60, c);
      wr(4'd0, 8'h00, c); chk("R5", "B indep keeps", c, 8'h00);
      wr(4'd12, 8'h00, c);
      wr(4'd0, 8'h00, c); chk("R5", "B write clears", c, 8'h18);
   endtask

   task automatic t_pulse;
      wr(4'd12, 8'h0A, c);
      wr(4'd1, 8'h00, c); #2 chk("R7", "ca2 low one cycle", {7'd0, ca2_o}, 8'h00);
      @(negedge clk); #2 chk("R7", "ca2 back high", {7'd0, ca2_o}, 8'h01);
      wr(4'd12, 8'hA0, c);
      wr(4'd0, 8'h00, c); #2 chk("R7", "cb2 low one cycle", {7'd0, cb2_o}, 8'h00);
      @(negedge clk); #2 chk("R7", "cb2 back high", {7'd0, cb2_o}, 8'h01);
   endtask

   task automatic t_manual;
      wr(4'd12, 8'h0C, c); #2
      chk("R9", "force low", {6'd0, ca2_oe, ca2_o}, 8'h02);
      wr(4'd12, 8'h0E, c); #2
      chk("R9", "force high", {6'd0, ca2_oe, ca2_o}, 8'h03);
      wr(4'd12, 8'h00, c); #2
      chk("R9", "input undriven", {6'd0, ca2_oe, ca2_o}, 8'h01);
   endtask

   task automatic t_handshake;
      @(negedge clk); ca1 = 1'b0;
      @(negedge clk);
      wr(4'd12, 8'h09, c);
      rd(4'd1, d, c, s); #2 chk("R8", "ca2 low after read", {7'd0, ca2_o}, 8'h00);
      @(negedge clk); @(negedge clk); #2 chk("R8", "ca2 held low", {7'd0, ca2_o}, 8'h00);
      @(negedge clk); ca1 = 1'b1;
      @(negedge clk); #2 chk("R8", "ca2 released by ca1", {7'd0, ca2_o}, 8'h01);
      wr(4'd12, 8'h80, c);
      wr(4'd0, 8'h00, c); #2 chk("R8", "cb2 low after write", {7'd0, cb2_o}, 8'h00);
      @(negedge clk); cb1 = 1'b0;
      @(negedge clk); #2 chk("R8", "cb2 released by cb1", {7'd0, cb2_o}, 8'h01);
      cb1 = 1'b1;
   endtask

   task automatic t_quiet;
      logic [7:0] dq;
      wr(4'd12, 8'h09, c);
      pa_pins = 8'h96;
      rd(4'd15, dq, c, s); chk("R6", "quiet no clear", c, 8'h00);
      #2 chk("R6", "quiet no handshake", {7'd0, ca2_o}, 8'h01);
      rd(4'd1, d, c, s); chk("R6", "quiet equals port A", dq, d);
      @(negedge clk); ca1 = 1'b0;
      @(negedge clk); ca1 = 1'b1;
      wr(4'd12, 8'h00, c);
   endtask

   task automatic t_collide;
      wr(4'd11, 8'h01, c);
      @(negedge clk); pa_pins = 8'h5E; ca1 = 1'b0;
      @(negedge clk); ca1 = 1'b1;
      @(negedge clk); pa_pins = 8'h42; ca1 = 1'b0; sel = 4'd1; rd_stb = 1'b1;
      #2;
      chk("R2", "collide reads old latch", rd_data, 8'h5E);
      chk("R5", "collide clear", fclr, 8'h03);
      chk("R3", "collide set", fset, 8'h02);
      @(negedge clk); rd_stb = 1'b0;
      rd(4'd1, d, c, s); chk("R2", "collide new latch", d, 8'h42);
   endtask

   initial begin
      #(20 * 200000);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_readback();
      t_merge();
      t_edge();
      t_latch();
      t_line2_in();
      t_clear();
      t_pulse();
      t_manual();
      t_handshake();
      t_quiet();
      t_collide();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule